// File: doc/BRIEF.md
# Shared-Clock Dual-Port RAM with Collision Classification

This block is a synchronous RAM with two fully independent request ports, A and B, on one common clock. Each port has an enable, an address, a per-byte write mask, a write word and a registered read word.

A port is active when its enable is high. An active port with a non-zero mask writes; with a zero mask it reads. An active port always returns the word held at its address once the current edge has been handled, so a writing port sees its own new data one cycle later.

Both requests arriving on the same edge are resolved as one combined step. When the two ports reach the same stored location and at least one of them writes, the block flags a collision. It also reports which ports wrote, so the consumer can tell a write-write clash from a read-write one. The flag and the type are registered, so they line up with the read words produced by the same edge.

Addresses at or above the configured depth name no location. Writes to them are dropped and reads from them return zero.

Top module: `dpc_ram_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both read words, the collision flag and the collision type are all zero.
- R2: A write changes only the byte lanes whose mask bit is set; lane i is bits 8*i+7 down to 8*i, and mask bit i selects lane i. Other lanes keep their stored value.
- R3: One cycle after an enabled port writes an in-range address, its read word equals the stored word after the write, with unselected lanes keeping their old contents. An enabled port with an all-zero mask reads, and returns the stored word one cycle later.
- R4: A port whose enable is low keeps its previous read word and changes no memory contents.
- R5: The collision flag is high one cycle after an edge on which all of the following hold: both ports were enabled, both addresses were in range and equal, and at least one mask was non-zero. Otherwise the flag is low.
- R6: The collision type is 2 bits. Bit 0 is set when port A wrote in the collision and bit 1 when port B wrote. So 2'b11 is write-write, 2'b01 means A wrote and B read, and 2'b10 means B wrote and A read. The type is 2'b00 whenever the flag is low.
- R7: On a write-write collision, port A's data wins on every lane selected in A's mask. Port B's data lands only on lanes selected by B and not by A. Both read words return the same combined word.
- R8: On a read-write collision, the reading port returns the newly written word, merged per lane with the old contents, in the same cycle as the writing port.
- R9: An address at or above DEPTH is ignored for writes, reads back zero on an enabled port, and never takes part in a collision.
- R10: The collision flag and type appear on the same cycle as the read words produced by the edge that caused them, one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| a_en | input | 1 | Port A request enable |
| a_addr | input | ADDR_W | Port A word address |
| a_be | input | DATA_W/8 | Port A byte-lane write mask (zero means read) |
| a_wdata | input | DATA_W | Port A write word |
| a_rdata | output | DATA_W | Port A registered read word |
| b_en | input | 1 | Port B request enable |
| b_addr | input | ADDR_W | Port B word address |
| b_be | input | DATA_W/8 | Port B byte-lane write mask (zero means read) |
| b_wdata | input | DATA_W | Port B write word |
| b_rdata | output | DATA_W | Port B registered read word |
| coll_valid | output | 1 | Registered collision flag |
| coll_kind | output | 2 | Registered collision type: bit 0 means A wrote, bit 1 means B wrote |

## Verification
The hardest situation to reach is a write-write collision in which the two masks partly overlap, because both ports must be enabled on the same edge, on the same in-range address, with different lane sets. Uniform random addresses almost never meet. The random stimulus therefore draws most addresses from a four-word window so that the ports meet often. It adds a few directed edges with hand-picked overlapping masks, read-write clashes in both directions, and clashes at out-of-range addresses. Every cycle is compared against a bench model that applies B's lanes first and then A's on top.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  localparam logic [1:0] KIND_NONE = 2'b00;
  localparam logic [1:0] KIND_A_WR = 2'b01;
  localparam logic [1:0] KIND_B_WR = 2'b10;
  localparam logic [1:0] KIND_BOTH = 2'b11;

  // Type code: one bit per writing port, forced to none when there is no hit.
  function automatic logic [1:0] classify(input logic hit, input logic wr_a, input logic wr_b);
    return hit ? {wr_b, wr_a} : KIND_NONE;
  endfunction

endpackage

// File: rtl/dpc_conflict.sv
module dpc_conflict #(
  parameter int ADDR_W = 7,
  parameter int LANES  = 4,
  parameter int DEPTH  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [LANES-1:0]  a_be,
  input  logic              b_en,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [LANES-1:0]  b_be,
  output logic              hit,
  output logic [1:0]        kind
);
  import dpc_pkg::*;

  localparam logic [ADDR_W:0] DEPTH_V = DEPTH[ADDR_W:0];

  logic a_in, b_in, a_wr, b_wr, same_loc;

  assign a_in     = ({1'b0, a_addr} < DEPTH_V);
  assign b_in     = ({1'b0, b_addr} < DEPTH_V);
  assign a_wr     = a_en && a_in && (|a_be);
  assign b_wr     = b_en && b_in && (|b_be);
  assign same_loc = a_en && b_en && a_in && b_in && (a_addr == b_addr);
  assign hit      = same_loc && (a_wr || b_wr);
  assign kind     = classify(hit, a_wr, b_wr);

  // R9: an out-of-range address never produces a hit
  a_r9_no_oob_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_in || !b_in) |-> !hit);
  // R6: a hit always names at least one writer
  a_r6_hit_has_writer: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (kind != KIND_NONE));

endmodule

// File: rtl/dpc_store.sv
module dpc_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 100,
  parameter int ADDR_W = 7
) (
  input  logic                clk,
  input  logic                a_en,
  input  logic [ADDR_W-1:0]   a_addr,
  input  logic [DATA_W/8-1:0] a_be,
  input  logic [DATA_W-1:0]   a_wdata,
  input  logic                b_en,
  input  logic [ADDR_W-1:0]   b_addr,
  input  logic [DATA_W/8-1:0] b_be,
  input  logic [DATA_W-1:0]   b_wdata,
  output logic [DATA_W-1:0]   a_word,
  output logic [DATA_W-1:0]   b_word
);
  localparam int LANES = DATA_W / 8;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W:0] DEPTH_V = DEPTH[ADDR_W:0];

  logic [DATA_W-1:0] mem [DEPTH];

  logic             a_in, b_in, same_loc, a_wr, b_wr;
  logic [IDX_W-1:0] a_idx, b_idx;
  logic [DATA_W-1:0] a_old, b_old;
  logic [LANES-1:0] a_sel, b_sel;

  assign a_in     = ({1'b0, a_addr} < DEPTH_V);
  assign b_in     = ({1'b0, b_addr} < DEPTH_V);
  assign a_idx    = a_in ? a_addr[IDX_W-1:0] : '0;
  assign b_idx    = b_in ? b_addr[IDX_W-1:0] : '0;
  assign a_old    = a_in ? mem[a_idx] : '0;
  assign b_old    = b_in ? mem[b_idx] : '0;
  assign a_sel    = (a_en && a_in) ? a_be : '0;
  assign b_sel    = (b_en && b_in) ? b_be : '0;
  assign a_wr     = |a_sel;
  assign b_wr     = |b_sel;
  assign same_loc = a_en && b_en && a_in && b_in && (a_addr == b_addr);

  // Lane-wise merge: lanes set in the mask take the new data.
  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [LANES-1:0] sel);
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++)
      if (sel[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
    return r;
  endfunction

  // Port A word: A lanes over B's lanes (when shared) over old contents.
  always_comb begin
    a_word = lane_merge(a_old, b_wdata, same_loc ? b_sel : '0);
    a_word = lane_merge(a_word, a_wdata, a_sel);
    if (same_loc) b_word = a_word;
    else          b_word = lane_merge(b_old, b_wdata, b_sel);
  end

  always_ff @(posedge clk) begin
    if (a_wr)                     mem[a_idx] <= a_word;
    if (b_wr && !(same_loc && a_wr)) mem[b_idx] <= b_word;
  end

endmodule

// File: rtl/dpc_ram_top.sv
module dpc_ram_top #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 100,
  parameter int ADDR_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                a_en,
  input  logic [ADDR_W-1:0]   a_addr,
  input  logic [DATA_W/8-1:0] a_be,
  input  logic [DATA_W-1:0]   a_wdata,
  output logic [DATA_W-1:0]   a_rdata,
  input  logic                b_en,
  input  logic [ADDR_W-1:0]   b_addr,
  input  logic [DATA_W/8-1:0] b_be,
  input  logic [DATA_W-1:0]   b_wdata,
  output logic [DATA_W-1:0]   b_rdata,
  output logic                coll_valid,
  output logic [1:0]          coll_kind
);
  import dpc_pkg::*;

  localparam int LANES = DATA_W / 8;
  localparam logic [ADDR_W:0] DEPTH_V = DEPTH[ADDR_W:0];

  logic [DATA_W-1:0] a_word, b_word;
  logic              hit_d;
  logic [1:0]        kind_d;
  logic              past_ok;

  dpc_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) store_i (
    .clk(clk),
    .a_en(a_en), .a_addr(a_addr), .a_be(a_be), .a_wdata(a_wdata),
    .b_en(b_en), .b_addr(b_addr), .b_be(b_be), .b_wdata(b_wdata),
    .a_word(a_word), .b_word(b_word)
  );

  dpc_conflict #(.ADDR_W(ADDR_W), .LANES(LANES), .DEPTH(DEPTH)) conflict_i (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_addr(a_addr), .a_be(a_be),
    .b_en(b_en), .b_addr(b_addr), .b_be(b_be),
    .hit(hit_d), .kind(kind_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata    <= '0;
      b_rdata    <= '0;
      coll_valid <= 1'b0;
      coll_kind  <= KIND_NONE;
      past_ok    <= 1'b0;
    end else begin
      if (a_en) a_rdata <= a_word;
      if (b_en) b_rdata <= b_word;
      coll_valid <= hit_d;
      coll_kind  <= kind_d;
      past_ok    <= 1'b1;
    end
  end

  // R6: type is none exactly when the flag is low
  a_r6_kind_matches_flag: assert property (@(posedge clk) disable iff (!rst_n)
    coll_valid == (coll_kind != KIND_NONE));
  // R7: a write-write collision leaves both ports with one word
  a_r7_ww_same_word: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_valid && coll_kind == KIND_BOTH) |-> (a_rdata == b_rdata));
  // R8: a read-write collision also gives both ports the same word
  a_r8_rw_same_word: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_valid && coll_kind != KIND_BOTH) |-> (a_rdata == b_rdata));
  // R4: a disabled port keeps its read word
  a_r4_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(a_en)) |-> $stable(a_rdata));
  a_r4_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(b_en)) |-> $stable(b_rdata));
  // R9: an enabled out-of-range read returns zero
  a_r9_oob_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(a_en) && ({1'b0, $past(a_addr)} >= DEPTH_V)) |-> (a_rdata == '0));
  // R10: the registered flag follows the request by one cycle
  a_r10_flag_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(a_en)) |-> !coll_valid);

endmodule

// File: tb/dpc_ram_top_tb_top.sv
module dpc_ram_top_tb_top;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 100;
  localparam int ADDR_W = 7;
  localparam int LANES  = DATA_W / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_en = 1'b0, b_en = 1'b0;
  logic [ADDR_W-1:0] a_addr = '0, b_addr = '0;
  logic [LANES-1:0]  a_be = '0, b_be = '0;
  logic [DATA_W-1:0] a_wdata = '0, b_wdata = '0;
  logic [DATA_W-1:0] a_rdata, b_rdata;
  logic coll_valid;
  logic [1:0] coll_kind;

  int checks = 0;
  int fails  = 0;

  logic [DATA_W-1:0] model [DEPTH];
  logic [DATA_W-1:0] exp_a = '0, exp_b = '0;

  always #10 clk = ~clk;

  dpc_ram_top #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_addr(a_addr), .a_be(a_be), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_addr(b_addr), .b_be(b_be), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .coll_valid(coll_valid), .coll_kind(coll_kind)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Byte patch applied lane by lane in the bench's own way.
  function automatic logic [DATA_W-1:0] patch(input logic [DATA_W-1:0] w,
                                              input logic [DATA_W-1:0] d,
                                              input logic [LANES-1:0] m);
    logic [DATA_W-1:0] bits;
    for (int k = 0; k < DATA_W; k++) bits[k] = m[k/8];
    return (w & ~bits) | (d & bits);
  endfunction

  task automatic step(input logic ea, input int aa, input logic [LANES-1:0] ma, input logic [DATA_W-1:0] da,
                      input logic eb, input int ab, input logic [LANES-1:0] mb, input logic [DATA_W-1:0] db);
    logic ina, inb, wa, wb, hit;
    logic [1:0] kind;
    string ta, tb;
    a_en = ea; a_addr = aa[ADDR_W-1:0]; a_be = ma; a_wdata = da;
    b_en = eb; b_addr = ab[ADDR_W-1:0]; b_be = mb; b_wdata = db;
    ina = aa < DEPTH; inb = ab < DEPTH;
    wa = ea && ina && (ma != 0);
    wb = eb && inb && (mb != 0);
    hit = ea && eb && ina && inb && (aa == ab) && (wa || wb);
    kind = hit ? {wb, wa} : 2'b00;
    // B first, A afterwards: A ends up owning its lanes.
    if (wb) model[ab] = patch(model[ab], db, mb);
    if (wa) model[aa] = patch(model[aa], da, ma);
    if (ea) exp_a = ina ? model[aa] : '0;
    if (eb) exp_b = inb ? model[ab] : '0;
    ta = !ea ? "R4" : !ina ? "R9" : (hit && kind == 2'b11) ? "R7" : hit ? "R8" : wa ? "R3 R2" : "R3";
    tb = !eb ? "R4" : !inb ? "R9" : (hit && kind == 2'b11) ? "R7" : hit ? "R8" : wb ? "R3 R2" : "R3";
    @(posedge clk);
    @(negedge clk);
    check({ta, " a_rdata"}, a_rdata, exp_a);
    check({tb, " b_rdata"}, b_rdata, exp_b);
    check("R5 R10 coll_valid", {{(DATA_W-1){1'b0}}, coll_valid}, {{(DATA_W-1){1'b0}}, hit});
    check("R6 coll_kind", {{(DATA_W-2){1'b0}}, coll_kind}, {{(DATA_W-2){1'b0}}, kind});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 a_rdata reset", a_rdata, '0);
    check("R1 coll_valid reset", {31'd0, coll_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 b_rdata after reset", b_rdata, '0);
    check("R1 coll_kind after reset", {30'd0, coll_kind}, '0);

    // Fill every location through port A.
    for (int i = 0; i < DEPTH; i++)
      step(1, i, 4'hF, 32'h1000_0000 + i * 32'h0101_0101, 0, 0, 4'h0, '0);

    // R2 / R3: partial-lane write then read back.
    step(1, 5, 4'b0101, 32'hAAAA_AAAA, 0, 0, 4'h0, '0);
    step(0, 0, 4'h0, '0, 1, 5, 4'h0, '0);
    // R7: write-write with overlapping masks.
    step(1, 7, 4'b0011, 32'h1111_1111, 1, 7, 4'b0110, 32'h2222_2222);
    // R8: A writes, B reads; then B writes, A reads.
    step(1, 9, 4'b1000, 32'hDEAD_BEEF, 1, 9, 4'h0, '0);
    step(1, 9, 4'h0, '0, 1, 9, 4'b0001, 32'h0000_00C3);
    // R5: both read the same word -> no collision.
    step(1, 3, 4'h0, '0, 1, 3, 4'h0, '0);
    // R9: out-of-range write ignored, reads zero, no collision.
    step(1, 110, 4'hF, 32'hFFFF_FFFF, 1, 110, 4'hF, 32'h1234_5678);
    step(1, 127, 4'h0, '0, 0, 0, 4'h0, '0);
    // R4: disabled port with a mask changes nothing.
    step(0, 11, 4'hF, 32'h0BAD_0BAD, 1, 11, 4'h0, '0);

    // Random traffic concentrated on a small window.
    for (int n = 0; n < 4000; n++) begin
      int pa, pb, ra, rb;
      logic [LANES-1:0] ma, mb;
      ra = $urandom_range(0, 9);
      rb = $urandom_range(0, 9);
      pa = (ra < 7) ? $urandom_range(0, 3) : (ra < 9) ? $urandom_range(0, DEPTH-1) : $urandom_range(DEPTH, 127);
      pb = (rb < 7) ? $urandom_range(0, 3) : (rb < 9) ? $urandom_range(0, DEPTH-1) : $urandom_range(DEPTH, 127);
      ma = ($urandom_range(0, 9) < 3) ? 4'h0 : 4'($urandom());
      mb = ($urandom_range(0, 9) < 3) ? 4'h0 : 4'($urandom());
      step($urandom_range(0, 9) < 8, pa, ma, $urandom(),
           $urandom_range(0, 9) < 8, pb, mb, $urandom());
    end

    summary();
    $finish;
  end

endmodule